// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block is the register bank that one processor core uses to receive inter-processor interrupts. It keeps a word of pending interrupt bits, a word of enable bits and eight 32-bit mailbox words. All of them sit behind a simple 32-bit register bus with one request per cycle. Other agents post interrupts by writing ones into a set port. The owning core acknowledges them by writing ones into a clear port. Mailbox words carry small payloads between cores.

The interrupt output is not a continuous AND of pending and enable bits. It is a stored level that changes only on a set-port write or a clear-port write, and each of the two has its own condition. A write to the enable word therefore never moves the line by itself. Every request gets a registered response one cycle later. Offsets that are not decoded read as zero, writes to them are dropped, and they never cause a bus error.

Top module: `ipi_core_bank`

## Requirements
- R1: After reset the pending word, the enable word, all eight mailbox words, `irq_o`, `rsp_valid`, `rsp_rdata` and `ro_wr_err` are zero.
- R2: The pending word is at offset 0x00 and is read-only. A write there leaves it unchanged and raises `ro_wr_err` for exactly the response cycle of that write.
- R3: A write to offset 0x04 replaces the whole enable word, and a read of 0x04 returns the stored word.
- R4: A write to offset 0x08 ORs the write data into the pending word. If the new pending word is nonzero and its AND with the enable word is nonzero, `irq_o` becomes 1.
- R5: A write to offset 0x0C clears the pending bits that are 1 in the write data. `irq_o` becomes 0 only when the new pending word is zero and the enable word is nonzero; otherwise it keeps its value.
- R6: `irq_o` keeps its value across every access other than a set-port or clear-port write, including writes to the enable word.
- R7: Reads of offsets 0x08 and 0x0C return zero.
- R8: Mailbox words occupy offsets 0x20 to 0x3C. Word index is (offset - 0x20) >> 2, and each word is written and read as a full 32 bits without disturbing the other words.
- R9: Only the low 8 bits of `req_addr` select a register. The higher bits and the two byte-offset bits have no effect.
- R10: Offsets 0x10 to 0x1C and 0x40 to 0xFC read as zero. Writes to them change no state, and they still get a normal response with `ro_wr_err` low.
- R11: Every cycle with `req_valid` high is followed, in the next cycle, by `rsp_valid` high. A cycle without a request is followed by `rsp_valid` low. `rsp_rdata` is zero in the response to a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte address; only bits 7:2 select a word |
| req_wdata | input | 32 | Write data, little-endian word |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data of the previous request, zero for writes |
| ro_wr_err | output | 1 | Previous request wrote the read-only pending word |
| irq_o | output | 1 | Stored interrupt level for this core |

## Verification
Every result of an access is due exactly one clock after the request edge. This covers the response data, the error flag and the new interrupt level, so a write's effect on `irq_o` shows up together with that write's own response. The driver presents a request at a falling edge and pushes the expected response, including the interrupt level after that access, into a queue. The monitor pops an item at each following falling edge where `rsp_valid` is high, so every comparison lands one full cycle after its stimulus and half a cycle away from any clock edge. Effects of writes that must be ignored are observed through later reads of the state those writes could have touched.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;

    // register bus word width
    localparam int REG_W = 32;

    // word offsets (byte offset >> 2) inside the decoded 8-bit window
    localparam logic [5:0] WORD_PEND   = 6'd0;   // 0x00
    localparam logic [5:0] WORD_ENABLE = 6'd1;   // 0x04
    localparam logic [5:0] WORD_SET    = 6'd2;   // 0x08
    localparam logic [5:0] WORD_CLEAR  = 6'd3;   // 0x0C
    localparam logic [5:0] WORD_MBX0   = 6'd8;   // 0x20

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENABLE,
        SEL_SET,
        SEL_CLEAR,
        SEL_MBX
    } reg_sel_e;

endpackage

// File: rtl/ipi_bank_decode.sv
module ipi_bank_decode
    import ipi_bank_pkg::*;
#(
    parameter int MBX_WORDS = 8,
    parameter int IDX_W     = 3
) (
    input  logic [5:0]       word_off,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] mbx_idx
);

    localparam int MBX_FIRST = int'(WORD_MBX0);
    localparam int MBX_LAST  = MBX_FIRST + MBX_WORDS - 1;

    logic [5:0] mbx_rel;

    always_comb begin
        mbx_rel = word_off - WORD_MBX0;
        mbx_idx = mbx_rel[IDX_W-1:0];
        if (word_off == WORD_PEND) begin
            sel = SEL_PEND;
        end else if (word_off == WORD_ENABLE) begin
            sel = SEL_ENABLE;
        end else if (word_off == WORD_SET) begin
            sel = SEL_SET;
        end else if (word_off == WORD_CLEAR) begin
            sel = SEL_CLEAR;
        end else if ((int'(word_off) >= MBX_FIRST) && (int'(word_off) <= MBX_LAST)) begin
            sel = SEL_MBX;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/ipi_bank_status.sv
module ipi_bank_status #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pend_q,
    output logic [DATA_W-1:0] enable_q,
    output logic              irq_q
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] enable;
        logic              irq;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) begin
            st_d.enable = wdata;
        end
        if (set_wr) begin
            st_d.pend = st_q.pend | wdata;
            if ((st_d.pend != '0) && ((st_d.pend & st_q.enable) != '0)) begin
                st_d.irq = 1'b1;
            end
        end
        if (clr_wr) begin
            st_d.pend = st_q.pend & ~wdata;
            if ((st_d.pend == '0) && (st_q.enable != '0)) begin
                st_d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q   = st_q.pend;
    assign enable_q = st_q.enable;
    assign irq_q    = st_q.irq;

    // R6
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(set_wr));

    // R5
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> ($past(clr_wr) && (pend_q == '0) && ($past(enable_q) != '0)));

    // R4
    set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R5
    clr_adds_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((pend_q & ~$past(pend_q)) == '0));

    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(pend_q));

    // R6
    enable_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !set_wr && !clr_wr) |=> $stable(irq_q));

endmodule

// File: rtl/ipi_bank_mailbox.sv
module ipi_bank_mailbox #(
    parameter int MBX_WORDS = 8,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mbx_d [MBX_WORDS];
    logic [DATA_W-1:0] mbx_q [MBX_WORDS];

    for (genvar g = 0; g < MBX_WORDS; g++) begin : g_word
        logic hit;

        always_comb begin
            hit      = wr && (int'(idx) == g);
            mbx_d[g] = hit ? wdata : mbx_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mbx_q[g] <= '0;
            end else begin
                mbx_q[g] <= mbx_d[g];
            end
        end

        // R8
        mbx_other_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && (int'(idx) == g)) |=> $stable(mbx_q[g]));
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < MBX_WORDS; i++) begin
            if (int'(idx) == i) begin
                rd_word = mbx_q[i];
            end
        end
    end

endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
    import ipi_bank_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MBX_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata,
    output logic             ro_wr_err,
    output logic             irq_o
);

    localparam int IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] rdata;
        logic             err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [5:0]       word_off;
    reg_sel_e         sel;
    logic [IDX_W-1:0] mbx_idx;
    logic             do_wr, do_rd;
    logic             en_wr, set_wr, clr_wr, mbx_wr;
    logic [REG_W-1:0] pend_q, enable_q, mbx_word;
    logic             irq_q;

    // address bits outside the decoded window are ignored
    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:8], req_addr[1:0]};

    assign word_off = req_addr[7:2];

    ipi_bank_decode #(
        .MBX_WORDS(MBX_WORDS),
        .IDX_W    (IDX_W)
    ) decode_i (
        .word_off(word_off),
        .sel     (sel),
        .mbx_idx (mbx_idx)
    );

    always_comb begin
        do_wr  = req_valid && req_write;
        do_rd  = req_valid && !req_write;
        en_wr  = do_wr && (sel == SEL_ENABLE);
        set_wr = do_wr && (sel == SEL_SET);
        clr_wr = do_wr && (sel == SEL_CLEAR);
        mbx_wr = do_wr && (sel == SEL_MBX);
    end

    ipi_bank_status #(
        .DATA_W(REG_W)
    ) status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (en_wr),
        .set_wr  (set_wr),
        .clr_wr  (clr_wr),
        .wdata   (req_wdata),
        .pend_q  (pend_q),
        .enable_q(enable_q),
        .irq_q   (irq_q)
    );

    ipi_bank_mailbox #(
        .MBX_WORDS(MBX_WORDS),
        .DATA_W   (REG_W),
        .IDX_W    (IDX_W)
    ) mailbox_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mbx_wr),
        .idx    (mbx_idx),
        .wdata  (req_wdata),
        .rd_word(mbx_word)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = do_wr && (sel == SEL_PEND);
        if (do_rd) begin
            unique case (sel)
                SEL_PEND:   rsp_d.rdata = pend_q;
                SEL_ENABLE: rsp_d.rdata = enable_q;
                SEL_MBX:    rsp_d.rdata = mbx_word;
                default:    rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign ro_wr_err = rsp_q.err;
    assign irq_o     = irq_q;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    write_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |=> (rsp_rdata == '0));

    // R7
    setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && ((sel == SEL_SET) || (sel == SEL_CLEAR))) |=> (rsp_rdata == '0));

    // R10
    undecoded_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && (sel == SEL_NONE)) |=> (rsp_rdata == '0));

    // R2
    ro_err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ro_wr_err |-> rsp_valid);

    // R3
    enable_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (enable_q == $past(req_wdata)));

endmodule

// File: tb/ipi_core_bank_tb_top.sv
`timescale 1ns/1ps
module ipi_core_bank_tb_top;

    localparam int ADDR_W = 16;
    localparam int DW     = 32;
    localparam int NMBX   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic            ro_wr_err;
    logic            irq_o;

    always #2 clk = ~clk;   // 250 MHz

    ipi_core_bank #(.ADDR_W(ADDR_W), .MBX_WORDS(NMBX)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .ro_wr_err(ro_wr_err),
        .irq_o    (irq_o)
    );

    typedef struct {
        logic [DW-1:0] rdata;
        logic          irq;
        logic          err;
        string         tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // reference state built from the requirements
    logic [DW-1:0] m_pend = '0;
    logic [DW-1:0] m_en   = '0;
    logic [DW-1:0] m_mbx [NMBX];
    logic          m_irq  = 1'b0;

    task automatic access(input bit wr, input logic [ADDR_W-1:0] addr,
                          input logic [DW-1:0] wd, input string tag);
        sb_item_t it;
        logic [5:0] w;
        w = addr[7:2];
        it.rdata = '0;
        it.err   = 1'b0;
        if (!wr) begin
            if (w == 6'd0)                        it.rdata = m_pend;
            else if (w == 6'd1)                   it.rdata = m_en;
            else if (w >= 6'd8 && w < 6'd8 + NMBX) it.rdata = m_mbx[w - 6'd8];
        end else begin
            if (w == 6'd0) begin
                it.err = 1'b1;
            end else if (w == 6'd1) begin
                m_en = wd;
            end else if (w == 6'd2) begin
                m_pend = m_pend | wd;
                if (m_pend != '0 && (m_pend & m_en) != '0) m_irq = 1'b1;
            end else if (w == 6'd3) begin
                m_pend = m_pend & ~wd;
                if (m_pend == '0 && m_en != '0) m_irq = 1'b0;
            end else if (w >= 6'd8 && w < 6'd8 + NMBX) begin
                m_mbx[w - 6'd8] = wd;
            end
        end
        it.irq = m_irq;
        it.tag = tag;
        sb_q.push_back(it);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // monitor: one response per request, due one cycle later
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R11 unexpected response actual rdata=%h expected none", rsp_rdata);
                end else begin
                    sb_item_t e;
                    e = sb_q.pop_front();
                    if (rsp_rdata !== e.rdata || irq_o !== e.irq || ro_wr_err !== e.err) begin
                        failures++;
                        $display("FAIL %s actual rdata=%h irq=%b err=%b expected rdata=%h irq=%b err=%b",
                                 e.tag, rsp_rdata, irq_o, ro_wr_err, e.rdata, e.irq, e.err);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NMBX; i++) m_mbx[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        checks++;
        if (irq_o !== 1'b0 || rsp_valid !== 1'b0 || rsp_rdata !== '0 || ro_wr_err !== 1'b0) begin
            failures++;
            $display("FAIL R1 actual irq=%b vld=%b rdata=%h err=%b expected all zero",
                     irq_o, rsp_valid, rsp_rdata, ro_wr_err);
        end
        // R1 reset contents
        access(0, 16'h0000, '0, "R1 pend");
        access(0, 16'h0004, '0, "R1 enable");
        access(0, 16'h0020, '0, "R1 mbx0");
        access(0, 16'h003C, '0, "R1 mbx7");
        // R3 enable replace and readback
        access(1, 16'h0004, 32'h0000_00F0, "R3 en write");
        access(0, 16'h0004, '0, "R3 en read");
        // R4 set without enabled bit: no irq
        access(1, 16'h0008, 32'h0000_0001, "R4 set masked");
        access(0, 16'h0000, '0, "R4 pend read");
        // R4 set with enabled bit: irq
        access(1, 16'h0008, 32'h0000_0010, "R4 set raise");
        // R6 enable write does not move irq
        access(1, 16'h0004, 32'h0000_0000, "R6 en clear keeps irq");
        // R2 write to pending ignored, flagged
        access(1, 16'h0000, 32'hFFFF_FFFF, "R2 ro write");
        access(0, 16'h0000, '0, "R2 pend unchanged");
        // R5 partial clear keeps irq
        access(1, 16'h000C, 32'h0000_0001, "R5 partial clear");
        // R5 clear to zero with enable zero keeps irq
        access(1, 16'h000C, 32'h0000_0010, "R5 clear en zero");
        access(0, 16'h0000, '0, "R5 pend zero");
        // R5 clear with nonzero enable and zero pending lowers irq
        access(1, 16'h0004, 32'h0000_000F, "R3 en write 2");
        access(1, 16'h000C, 32'h0000_0000, "R5 lower");
        // R4 set of disabled bit keeps irq low, then enabled bit raises
        access(1, 16'h0008, 32'h0000_0100, "R4 set disabled");
        access(1, 16'h0008, 32'h0000_0002, "R4 set enabled");
        // R7 set/clear read zero
        access(0, 16'h0008, '0, "R7 set read");
        access(0, 16'h000C, '0, "R7 clear read");
        // R8 mailbox words
        for (int i = 0; i < NMBX; i++)
            access(1, 16'(16'h0020 + 4 * i), 32'hA5A5_0000 + 32'(i * 32'h0101_0101), "R8 mbx write");
        for (int i = 0; i < NMBX; i++)
            access(0, 16'(16'h0020 + 4 * i), '0, "R8 mbx read");
        // R9 upper and byte bits ignored
        access(1, 16'hAB27, 32'hDEAD_BEEF, "R9 alias write");
        access(0, 16'h0024, '0, "R9 alias read");
        access(0, 16'h7F04, '0, "R9 alias en");
        // R10 undecoded offsets
        access(1, 16'h0010, 32'hFFFF_FFFF, "R10 write 0x10");
        access(1, 16'h0040, 32'hFFFF_FFFF, "R10 write 0x40");
        access(1, 16'h00FC, 32'hFFFF_FFFF, "R10 write 0xFC");
        access(0, 16'h0010, '0, "R10 read 0x10");
        access(0, 16'h0044, '0, "R10 read 0x44");
        access(0, 16'h0000, '0, "R10 pend kept");
        access(0, 16'h0004, '0, "R10 en kept");
        for (int i = 0; i < NMBX; i++)
            access(0, 16'(16'h0020 + 4 * i), '0, "R10 mbx kept");
        // R11 idle cycles give no response
        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R11 actual pending=%0d expected 0", sb_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule